// File: doc/BRIEF.md
# Global-Clock Write Adapter with Register Array

This block is a small register array whose write port was described against a separate write clock. That clock has been brought onto the single global clock as an ordinary data signal. On every global edge the block samples the modelled write clock. It keeps the previous sample and compares the two to find the active edge of the write clock. The polarity of that edge is set by a parameter.

The per-bit write enable, the write address and the write data are registered on every global cycle. When an edge is detected, the registered values from the cycle before are committed to the array. On every other cycle the effective enable is forced to all zeros. The read port is purely combinational. There is no registered read.

The block is meant for flows that must model a multi-clock memory in a single-clock environment, such as formal checking or cycle-based simulation. The rest of the system then needs only the global clock.

Top module: `gclk_wr_adapter`

## Requirements
- R1: After a synchronous active-low reset, every array word reads as zero.
- R2: The stored previous write-clock sample resets to 1 when `RISE_POL`=1 and to 0 when `RISE_POL`=0. A first post-reset sample equal to that value therefore causes no write, even with the enable set.
- R3: With `RISE_POL`=1, a write is committed in a global cycle whose current write-clock sample is 1 and whose previous sample was 0.
- R4: With `RISE_POL`=0, a write is committed in a global cycle whose current write-clock sample is 0 and whose previous sample was 1.
- R5: A committed write uses the enable, address and data present at the global edge one cycle before the edge cycle. Values driven during the edge cycle itself are not used for that write.
- R6: In a cycle without a detected edge the array is unchanged, whatever the enable, address and data.
- R7: Bit i of the addressed word takes the new data only when bit i of the sampled enable is 1. Bits whose enable bit is 0 keep their value.
- R8: `rd_data` equals the word at `rd_addr` in the same cycle, with no register on the read path.
- R9: During the edge cycle, the written word still reads its old value. The new value reads from the following global cycle onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Global clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wclk_smp | input | 1 | Modelled write clock, treated as data |
| wr_be | input | DATA_W | Per-bit write enable |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Combinational read data |

## Verification
The interesting collision is a detected write-clock edge in the same cycle as new enable, address and data values. The commit must take the values from the previous cycle and ignore the ones arriving with the edge. The bench changes all three inputs on exactly the cycle that the modelled clock toggles, for every address and several enable masks. It runs two instances of opposite polarity on the same stimulus, so each toggle is an edge for one instance and not for the other. Each array word is compared against a bench model after every cycle. The old value is also read back inside the edge cycle, to judge the commit cycle.

// File: rtl/gca_pkg.sv
// Package: shared polarity type and edge-match function for the adapter.
// Assumes: the modelled clock is sampled once per global cycle.
package gca_pkg;

    typedef enum logic {
        POL_FALL = 1'b0,
        POL_RISE = 1'b1
    } wclk_pol_e;

    // True when (current, previous) samples form the active transition.
    function automatic logic pol_transition(input logic pol, input logic cur, input logic prev);
        return (cur == pol) && (prev != pol);
    endfunction

endpackage

// File: rtl/gca_clk_tracker.sv
// Module: keeps the previous sample of the modelled write clock and flags
// the active transition. Assumes the write clock changes no faster than
// once per global cycle to be seen at all.
module gca_clk_tracker #(
    parameter bit RISE_POL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wclk_smp,
    output logic prev_clk,
    output logic edge_hit
);
    import gca_pkg::*;

    localparam wclk_pol_e POL = RISE_POL ? POL_RISE : POL_FALL;

    // Hold last sample; reset to the inactive-before-edge level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_clk <= RISE_POL;
        else        prev_clk <= wclk_smp;
    end

    // Flag the active transition between previous and current samples.
    always_comb begin
        edge_hit = pol_transition(POL, wclk_smp, prev_clk);
    end
endmodule

// File: rtl/gca_port_sampler.sv
// Module: registers enable, address and data each global cycle. These are
// datapath registers without reset; their value is only used under a gated
// enable, so an unknown start is harmless.
module gca_port_sampler #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic [DATA_W-1:0] wr_be,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] be_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);
    // Capture the write request every global cycle.
    always_ff @(posedge clk) begin
        be_q   <= wr_be;
        addr_q <= wr_addr;
        data_q <= wr_data;
    end
endmodule

// File: rtl/gca_en_gate.sv
// Module: forces the registered per-bit enable to zero except in the edge
// cycle. Pure combinational logic.
module gca_en_gate #(
    parameter int DATA_W = 8
) (
    input  logic              edge_hit,
    input  logic [DATA_W-1:0] be_q,
    output logic [DATA_W-1:0] eff_be
);
    // Replicate the edge flag across the enable vector.
    always_comb begin
        eff_be = be_q & {DATA_W{edge_hit}};
    end
endmodule

// File: rtl/gca_store.sv
// Module: register array with a bit-masked write on the global clock and an
// unregistered read. Assumes DEPTH = 2**ADDR_W.
module gca_store #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] eff_be,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    // Clear on reset, otherwise merge masked data into the addressed word.
    always_ff @(posedge clk) begin
        for (int r = 0; r < DEPTH; r++) begin
            if (!rst_n)
                words[r] <= '0;
            else if (waddr == ADDR_W'(r))
                words[r] <= (words[r] & ~eff_be) | (wdata & eff_be);
        end
    end

    // Combinational read.
    always_comb begin
        rd_data = words[rd_addr];
    end
endmodule

// File: rtl/gclk_wr_adapter.sv
// Module: top of the global-clock write adapter. Samples the modelled write
// clock, registers the write request, and commits it in the edge cycle.
// Assumes a single write port and a single combinational read port.
module gclk_wr_adapter #(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 8,
    parameter bit RISE_POL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wclk_smp,
    input  logic [DATA_W-1:0] wr_be,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic              prev_clk;
    logic              edge_hit;
    logic [DATA_W-1:0] be_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] eff_be;

    gca_clk_tracker #(.RISE_POL(RISE_POL)) u_trk (
        .clk(clk), .rst_n(rst_n), .wclk_smp(wclk_smp),
        .prev_clk(prev_clk), .edge_hit(edge_hit)
    );

    gca_port_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_smp (
        .clk(clk), .wr_be(wr_be), .wr_addr(wr_addr), .wr_data(wr_data),
        .be_q(be_q), .addr_q(addr_q), .data_q(data_q)
    );

    gca_en_gate #(.DATA_W(DATA_W)) u_gate (
        .edge_hit(edge_hit), .be_q(be_q), .eff_be(eff_be)
    );

    gca_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .eff_be(eff_be), .waddr(addr_q),
        .wdata(data_q), .rd_addr(rd_addr), .rd_data(rd_data)
    );
endmodule

// File: rtl/gca_checker.sv
// Module: property checker bound into the adapter top.
module gca_checker #(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 8,
    parameter bit RISE_POL = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wclk_smp,
    input logic              prev_clk,
    input logic              edge_hit,
    input logic [DATA_W-1:0] eff_be,
    input logic [ADDR_W-1:0] waddr,
    input logic [DATA_W-1:0] wdata,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data
);
    logic armed;

    // Set one cycle after reset so $past of the port is meaningful.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R2: previous sample tracks the port one cycle later.
    assert_prev_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (prev_clk == $past(wclk_smp)));

    // R3 / R4: a flagged edge matches the port history and polarity.
    assert_edge_pol_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && edge_hit) |-> (wclk_smp == RISE_POL && $past(wclk_smp) != RISE_POL));

    // R6: no enable reaches the array without an edge.
    assert_gate_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_hit |-> (eff_be == '0));

    // R6: read word is stable across a cycle with no edge.
    assert_hold_no_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !edge_hit) |=> (!$stable(rd_addr) || $stable(rd_data)));

    // R7 / R9: enabled bits carry the sampled data in the next cycle.
    assert_written_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_be != '0 && rd_addr == waddr) |=>
        (!$stable(rd_addr) || ((rd_data & $past(eff_be)) == ($past(wdata) & $past(eff_be)))));

    // R7: disabled bits of the written word keep their value.
    assert_kept_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && rd_addr == waddr) |=>
        (!$stable(rd_addr) || (((rd_data ^ $past(rd_data)) & ~$past(eff_be)) == '0)));
endmodule

bind gclk_wr_adapter gca_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RISE_POL(RISE_POL)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wclk_smp(wclk_smp), .prev_clk(prev_clk),
    .edge_hit(edge_hit), .eff_be(eff_be), .waddr(addr_q), .wdata(data_q),
    .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/sim_gclk_wr_adapter.sv
module sim_gclk_wr_adapter;
    localparam int CLK_P = 20;
    localparam int AW    = 3;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mclk = 1'b1;
    logic [DW-1:0] be = '0, wd = '0;
    logic [AW-1:0] wa = '0, ra = '0;
    logic [DW-1:0] rd0, rd1;

    int n_cmp = 0;
    int n_bad = 0;

    // Bench model: index 0 rising instance, index 1 falling instance.
    logic [DW-1:0] mm [2][DEPTH];
    logic          mprev [2];
    logic [DW-1:0] be_m = '0, wd_m = '0;
    logic [AW-1:0] wa_m = '0;

    gclk_wr_adapter #(.ADDR_W(AW), .DATA_W(DW), .RISE_POL(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .wclk_smp(mclk), .wr_be(be), .wr_addr(wa),
        .wr_data(wd), .rd_addr(ra), .rd_data(rd0));

    gclk_wr_adapter #(.ADDR_W(AW), .DATA_W(DW), .RISE_POL(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .wclk_smp(mclk), .wr_be(be), .wr_addr(wa),
        .wr_data(wd), .rd_addr(ra), .rd_data(rd1));

    always #(CLK_P/2) clk = ~clk;

    task automatic cmp(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp,
                       input int inst, input int a);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s inst%0d addr %0d: actual %h expected %h", tag, inst, a, act, exp);
        end
    endtask

    // Advance the model by one global edge, using current inputs.
    task automatic model_tick();
        for (int i = 0; i < 2; i++) begin
            if (!rst_n) begin
                for (int r = 0; r < DEPTH; r++) mm[i][r] = '0;
                mprev[i] = (i == 0);
            end else begin
                logic hit;
                hit = (i == 0) ? (mclk && !mprev[i]) : (!mclk && mprev[i]);
                if (hit) mm[i][wa_m] = (mm[i][wa_m] & ~be_m) | (wd_m & be_m);
                mprev[i] = mclk;
            end
        end
        be_m = be; wa_m = wa; wd_m = wd;
    endtask

    // R8: combinational read of every word, both instances.
    task automatic sweep(input string tag);
        for (int a = 0; a < DEPTH; a++) begin
            ra = AW'(a);
            #1;
            cmp(tag, rd0, mm[0][a], 0, a);
            cmp(tag, rd1, mm[1][a], 1, a);
        end
    endtask

    task automatic step(input logic mc, input logic [DW-1:0] b, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input string tag);
        @(negedge clk);
        mclk = mc; be = b; wa = a; wd = d;
        ra = wa_m;
        #1;
        // R9: within the edge cycle the target word still holds its old value.
        cmp("R9", rd0, mm[0][wa_m], 0, int'(wa_m));
        cmp("R9", rd1, mm[1][wa_m], 1, int'(wa_m));
        @(posedge clk);
        #1;
        model_tick();
        sweep(tag);
    endtask

    task automatic do_reset(input logic mc, input logic [DW-1:0] b, input logic [AW-1:0] a,
                            input logic [DW-1:0] d);
        @(negedge clk);
        rst_n = 1'b0; mclk = mc; be = b; wa = a; wd = d;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            #1;
            model_tick();
        end
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        // R1 / R2: reset with clock high and a full enable pending.
        do_reset(1'b1, 8'hFF, 3'd3, 8'h5A);
        sweep("R1");
        step(1'b1, 8'hFF, 3'd3, 8'hC3, "R2");
        step(1'b1, 8'hFF, 3'd5, 8'h3C, "R2");
        // R2: reset with clock low for the falling instance.
        do_reset(1'b0, 8'hFF, 3'd6, 8'h96);
        sweep("R1");
        step(1'b0, 8'hFF, 3'd6, 8'h69, "R2");
        step(1'b0, 8'hFF, 3'd2, 8'h77, "R2");
        // R6: clock held, enables and data changing, no writes.
        for (int k = 0; k < 6; k++)
            step(1'b0, 8'hFF, AW'(k), DW'(k * 37 + 1), "R6");
        // R3 / R4 / R5 / R7: toggles with new inputs on the edge cycle.
        for (int a = 0; a < DEPTH; a++) begin
            for (int k = 0; k < 4; k++) begin
                logic [DW-1:0] b, d;
                b = DW'((8'h5A << k) | k);
                d = DW'(a * 29 + k * 71 + 5);
                step(1'b1, b, AW'(a), d, "R3/R5/R7");
                step(1'b0, ~b, AW'(a + 1), ~d, "R4/R5/R7");
            end
        end
        // R3 / R4 / R6 / R7: pseudo-random clock and request pattern.
        lf = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[0] ^ lf[7], DW'(lf[15:8] ^ lf[7:0]), AW'(lf[3:1]), DW'(lf[11:4]),
                 "R3/R4/R6/R7");
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule